// File: doc/BRIEF.md
# Power-Down and Wakeup Sequencer

This block sequences a chip into and out of its low-power state. Software running on the core writes a 1 to the power-control bit. The sequencer then drops the oscillator enable, the PLL enable and the core clock gate together. Three wake sources can end the power-down: a bus-resume indication, a dedicated wake pin and a secondary wake pin. The secondary pin can be handed over to general-purpose I/O use, and while it is in that mode it cannot wake the chip.

On a wake edge the oscillator and PLL enables return at once. The core clock stays gated through a settle window whose length is a parameter in cycles, modelling the PLL lock time. When the window ends, the core clock is released and a one-cycle wakeup interrupt fires. A sticky status register records which sources fired during power-down and settle, and software clears its bits by writing ones to them. The sequencer runs from an always-on low-rate clock, so its own timing does not depend on the oscillator it controls. The sequence is identical whether or not the bus is attached.

Top module: `pwr_wake_seq`

## Requirements
- R1: After reset the sequencer is running: `osc_en_o`, `pll_en_o` and `core_clk_en_o` are 1, `wake_irq_o` is 0 and `wake_status_o` is 0.
- R2: In the running state, a cycle with `pctl_we_i`=1 and `pctl_wbit_i`=1 makes `osc_en_o`, `pll_en_o` and `core_clk_en_o` all 0 from the next cycle. A write with `pctl_wbit_i`=0 changes nothing.
- R3: While powered down, all three enables stay 0 until an enabled wake source shows a rising edge after synchronisation.
- R4: A wake edge on bus resume (status bit 0), the wake pin (bit 1) or the secondary pin (bit 2) in power-down raises `osc_en_o` and `pll_en_o` while `core_clk_en_o` stays 0.
- R5: `core_clk_en_o` rises exactly `SETTLE_CYCLES` cycles after `osc_en_o` rises.
- R6: `wake_irq_o` is 1 for exactly one cycle, the first cycle in which `core_clk_en_o` is 1 again.
- R7: A wake edge during power-down or settle sets its status bit (bit 0 bus resume, bit 1 wake pin, bit 2 secondary pin). An edge while running sets nothing.
- R8: A wake edge during the settle window sets its status bit but does not restart the window. A power-control write during the window is ignored.
- R9: A cycle with `stat_we_i`=1 clears every status bit whose `stat_wbits_i` bit is 1 and leaves the other bits unchanged. A status bit never clears without such a write.
- R10: With `aux_gpio_mode_i`=1, edges on the secondary pin neither wake the chip nor set status bit 2. The other two sources are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pctl_we_i | input | 1 | Power-control register write strobe |
| pctl_wbit_i | input | 1 | Power-down request bit written with the strobe |
| stat_we_i | input | 1 | Status register write strobe |
| stat_wbits_i | input | 3 | Write-one-to-clear mask for the status bits |
| bus_resume_i | input | 1 | Bus resume indication (wake source 0) |
| wake_pin_i | input | 1 | Dedicated wake pin (wake source 1) |
| wake_aux_i | input | 1 | Secondary wake pin (wake source 2) |
| aux_gpio_mode_i | input | 1 | 1 hands the secondary pin to GPIO use and masks it as a wake source |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| core_clk_en_o | output | 1 | Core clock gate enable |
| wake_irq_o | output | 1 | One-cycle wakeup interrupt |
| wake_status_o | output | 3 | Sticky wake source bits |

## Verification
The bench builds the sequencer with `SETTLE_CYCLES` set to 20, down from the default, and with `SYNC_STAGES` at 3. The shorter window lets each wake and its measured settle length fit in a short run many times over. It also leaves room to inject a second wake source and a stray power-control write partway through the window. Three synchroniser stages, rather than the minimum two, exercise the general shift path of the input stage. The polarity parameter is left at its active-high default.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

   localparam int NUM_WAKE = 3;
   localparam int SRC_BUS  = 0;
   localparam int SRC_PIN  = 1;
   localparam int SRC_AUX  = 2;

   typedef enum logic [1:0] {
      PW_RUN    = 2'd0,
      PW_DOWN   = 2'd1,
      PW_SETTLE = 2'd2
   } pw_state_e;

endpackage

// File: rtl/pw_wake_sync.sv
// One wake input: optional inversion, a synchroniser chain, rising-edge pulse.
module pw_wake_sync #(
   parameter int STAGES     = 2,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic rise_o
);

   logic             level;
   logic [STAGES-1:0] chain_q;
   logic             prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pw_wake_sync: STAGES must be at least 2");
      end
      if (ACTIVE_LOW) begin : g_inv
         assign level = ~pin_i;
      end else begin : g_pass
         assign level = pin_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], level};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pw_settle_timer.sv
// Counts the settle window; done_o is high in its last cycle.
module pw_settle_timer #(
   parameter int CYCLES = 9600
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic run_i,
   output logic done_o
);

   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("pw_settle_timer: CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= '0;
      end else if (run_i && !done_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/pw_wake_status.sv
// Sticky source bits, write-one-to-clear; a set in the same cycle wins.
module pw_wake_status #(
   parameter int N = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic         we_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o
);

   logic [N-1:0] stat_q;

   generate
      for (genvar b = 0; b < N; b++) begin : g_bit
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               stat_q[b] <= 1'b0;
            end else if (set_i[b]) begin
               stat_q[b] <= 1'b1;
            end else if (we_i && clr_i[b]) begin
               stat_q[b] <= 1'b0;
            end
         end
      end
   endgenerate

   assign stat_o = stat_q;

endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
   import pwr_wake_pkg::*;
#(
   parameter int                 SETTLE_CYCLES   = 9600,
   parameter int                 SYNC_STAGES     = 2,
   parameter logic [NUM_WAKE-1:0] WAKE_ACTIVE_LOW = '0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                pctl_we_i,
   input  logic                pctl_wbit_i,
   input  logic                stat_we_i,
   input  logic [NUM_WAKE-1:0] stat_wbits_i,
   input  logic                bus_resume_i,
   input  logic                wake_pin_i,
   input  logic                wake_aux_i,
   input  logic                aux_gpio_mode_i,
   output logic                osc_en_o,
   output logic                pll_en_o,
   output logic                core_clk_en_o,
   output logic                wake_irq_o,
   output logic [NUM_WAKE-1:0] wake_status_o
);

   pw_state_e           state_q, state_d;
   logic [NUM_WAKE-1:0] pins, rise, src_mask, wake_ev, record;
   logic                any_wake, settle_done, irq_q;

   generate
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("pwr_wake_seq: SETTLE_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwr_wake_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   assign pins[SRC_BUS] = bus_resume_i;
   assign pins[SRC_PIN] = wake_pin_i;
   assign pins[SRC_AUX] = wake_aux_i;

   generate
      for (genvar g = 0; g < NUM_WAKE; g++) begin : g_src
         pw_wake_sync #(
            .STAGES    (SYNC_STAGES),
            .ACTIVE_LOW(WAKE_ACTIVE_LOW[g])
         ) u_sync (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .pin_i (pins[g]),
            .rise_o(rise[g])
         );
         if (g == SRC_AUX) begin : g_gpio_mask
            assign src_mask[g] = ~aux_gpio_mode_i;
         end else begin : g_always_on
            assign src_mask[g] = 1'b1;
         end
      end
   endgenerate

   assign wake_ev  = rise & src_mask;
   assign any_wake = |wake_ev;
   assign record   = (state_q != PW_RUN) ? wake_ev : '0;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PW_RUN:    if (pctl_we_i && pctl_wbit_i) state_d = PW_DOWN;
         PW_DOWN:   if (any_wake)                 state_d = PW_SETTLE;
         PW_SETTLE: if (settle_done)              state_d = PW_RUN;
         default:                                 state_d = PW_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= PW_RUN;
         irq_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         irq_q   <= (state_q == PW_SETTLE) && settle_done;
      end
   end

   pw_settle_timer #(
      .CYCLES(SETTLE_CYCLES)
   ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i((state_q == PW_DOWN) && any_wake),
      .run_i  (state_q == PW_SETTLE),
      .done_o (settle_done)
   );

   pw_wake_status #(
      .N(NUM_WAKE)
   ) u_status (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (record),
      .we_i  (stat_we_i),
      .clr_i (stat_wbits_i),
      .stat_o(wake_status_o)
   );

   assign osc_en_o      = (state_q != PW_DOWN);
   assign pll_en_o      = (state_q != PW_DOWN);
   assign core_clk_en_o = (state_q == PW_RUN);
   assign wake_irq_o    = irq_q;

endmodule

// File: rtl/pwr_wake_seq_chk.sv
module pwr_wake_seq_chk #(
   parameter int SETTLE_CYCLES = 9600,
   parameter int N             = 3
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         pctl_we_i,
   input logic         pctl_wbit_i,
   input logic         stat_we_i,
   input logic         osc_en_o,
   input logic         pll_en_o,
   input logic         core_clk_en_o,
   input logic         wake_irq_o,
   input logic [N-1:0] wake_status_o
);

   localparam int CW = $clog2(SETTLE_CYCLES + 2) + 1;
   localparam logic [CW-1:0] CMAX = '1;

   logic [CW-1:0] gap_q;

   // cycles spent with the oscillator up but the core still gated
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q <= '0;
      end else if (osc_en_o && !core_clk_en_o) begin
         if (gap_q != CMAX) gap_q <= gap_q + 1'b1;
      end else begin
         gap_q <= '0;
      end
   end

   assert_pd_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (core_clk_en_o && pctl_we_i && pctl_wbit_i) |=> (!osc_en_o && !pll_en_o && !core_clk_en_o));

   assert_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !osc_en_o |-> (!core_clk_en_o && !pll_en_o));

   assert_wake_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(osc_en_o) |-> (pll_en_o && !core_clk_en_o));

   assert_settle_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(core_clk_en_o) |-> (gap_q == CW'(SETTLE_CYCLES)));

   assert_irq_at_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_irq_o |-> $rose(core_clk_en_o));

   assert_irq_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_irq_o |=> !wake_irq_o);

   assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stat_we_i |=> ((wake_status_o & $past(wake_status_o)) == $past(wake_status_o)));

endmodule

bind pwr_wake_seq pwr_wake_seq_chk #(
   .SETTLE_CYCLES(SETTLE_CYCLES),
   .N            (pwr_wake_pkg::NUM_WAKE)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .pctl_we_i    (pctl_we_i),
   .pctl_wbit_i  (pctl_wbit_i),
   .stat_we_i    (stat_we_i),
   .osc_en_o     (osc_en_o),
   .pll_en_o     (pll_en_o),
   .core_clk_en_o(core_clk_en_o),
   .wake_irq_o   (wake_irq_o),
   .wake_status_o(wake_status_o)
);

// File: tb/pwr_wake_seq_tb.sv
module pwr_wake_seq_tb;

   localparam int S    = 20;
   localparam int SYNC = 3;

   // entry: [7:6] source, [5] secondary pin in GPIO mode, [4] wake expected, [2:0] status expected
   localparam logic [7:0] VEC [6] = '{
      8'b00_0_1_0_001,
      8'b01_0_1_0_010,
      8'b10_0_1_0_100,
      8'b10_1_0_0_000,
      8'b01_1_1_0_010,
      8'b00_1_1_0_001
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       pctl_we, pctl_wbit, stat_we;
   logic [2:0] stat_wbits;
   logic       bus_resume, wake_pin, wake_aux, aux_gpio;
   logic       osc_en, pll_en, core_en, irq;
   logic [2:0] status;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pwr_wake_seq #(
      .SETTLE_CYCLES(S),
      .SYNC_STAGES  (SYNC)
   ) u_dut (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .pctl_we_i      (pctl_we),
      .pctl_wbit_i    (pctl_wbit),
      .stat_we_i      (stat_we),
      .stat_wbits_i   (stat_wbits),
      .bus_resume_i   (bus_resume),
      .wake_pin_i     (wake_pin),
      .wake_aux_i     (wake_aux),
      .aux_gpio_mode_i(aux_gpio),
      .osc_en_o       (osc_en),
      .pll_en_o       (pll_en),
      .core_clk_en_o  (core_en),
      .wake_irq_o     (irq),
      .wake_status_o  (status)
   );

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_src(input int s, input logic v);
      case (s)
         0:       bus_resume = v;
         1:       wake_pin   = v;
         default: wake_aux   = v;
      endcase
   endtask

   task automatic power_down();
      pctl_we = 1'b1; pctl_wbit = 1'b1;
      step();
      pctl_we = 1'b0; pctl_wbit = 1'b0;
   endtask

   task automatic clear_status();
      stat_we = 1'b1; stat_wbits = 3'b111;
      step();
      stat_we = 1'b0; stat_wbits = 3'b000;
   endtask

   task automatic wait_osc(output int n);
      n = 0;
      while (!osc_en && n < 12) begin
         step();
         n++;
      end
   endtask

   task automatic wait_core(output int n);
      n = 0;
      while (!core_en && n < S + 10) begin
         step();
         n++;
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         summary();
         $finish;
      end
   end

   initial begin
      int n, m;
      rst_n = 1'b0;
      pctl_we = 1'b0; pctl_wbit = 1'b0; stat_we = 1'b0; stat_wbits = 3'b000;
      bus_resume = 1'b0; wake_pin = 1'b0; wake_aux = 1'b0; aux_gpio = 1'b0;
      step(); step(); step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      chk(osc_en && pll_en && core_en, "R1 enables", {osc_en, pll_en, core_en}, 7);
      chk(!irq, "R1 irq", irq, 0);
      chk(status == 3'b000, "R1 status", status, 0);

      // R2 write of 0 leaves the chip running
      pctl_we = 1'b1; pctl_wbit = 1'b0;
      step();
      pctl_we = 1'b0;
      chk(osc_en && core_en, "R2 zero write", {osc_en, core_en}, 3);

      // R7 edge while running records nothing
      wake_aux = 1'b1;
      repeat (6) step();
      wake_aux = 1'b0;
      step();
      chk(status == 3'b000, "R7 run edge", status, 0);
      chk(core_en && !irq, "R7 run state", {core_en, irq}, 2);

      // table walk over sources and GPIO mode
      for (int i = 0; i < 6; i++) begin
         int  src;
         bit  gpio, expw;
         logic [2:0] exps;
         src  = int'(VEC[i][7:6]);
         gpio = VEC[i][5];
         expw = VEC[i][4];
         exps = VEC[i][2:0];
         aux_gpio = gpio;
         clear_status();
         power_down();
         chk(!osc_en && !pll_en && !core_en, "R2 entry", {osc_en, pll_en, core_en}, 0);
         repeat (3) step();
         chk(!osc_en && !core_en, "R3 stays down", {osc_en, core_en}, 0);
         set_src(src, 1'b1);
         wait_osc(n);
         set_src(src, 1'b0);
         if (expw) begin
            chk(osc_en && pll_en, "R4 osc restart", {osc_en, pll_en}, 3);
            chk(!core_en, "R4 core gated", core_en, 0);
            wait_core(n);
            chk(n == S, "R5 settle length", n, S);
            chk(irq, "R6 irq raised", irq, 1);
            chk(status == exps, "R7 source bit", status, exps);
            step();
            chk(!irq, "R6 irq single", irq, 0);
         end else begin
            chk(!osc_en, "R10 gpio no wake", osc_en, 0);
            chk(status == 3'b000, "R10 gpio no status", status, 0);
            bus_resume = 1'b1;
            wait_osc(n);
            bus_resume = 1'b0;
            wait_core(n);
            step();
         end
         aux_gpio = 1'b0;
      end

      // R8 wake and write during settle
      clear_status();
      power_down();
      bus_resume = 1'b1;
      wait_osc(n);
      bus_resume = 1'b0;
      step(); step();
      wake_pin = 1'b1;
      step(); step();
      pctl_we = 1'b1; pctl_wbit = 1'b1;
      step();
      pctl_we = 1'b0; pctl_wbit = 1'b0;
      step();
      wake_pin = 1'b0;
      chk(!core_en && osc_en, "R8 still settling", {osc_en, core_en}, 2);
      wait_core(m);
      chk(m + 6 == S, "R8 no restart", m + 6, S);
      chk(status == 3'b011, "R8 recorded", status, 3);
      chk(irq, "R8 irq", irq, 1);
      step();

      // R9 write-one-to-clear
      stat_we = 1'b1; stat_wbits = 3'b001;
      step();
      chk(status == 3'b010, "R9 clear bit0", status, 2);
      stat_wbits = 3'b000;
      step();
      chk(status == 3'b010, "R9 zero mask", status, 2);
      stat_wbits = 3'b110;
      step();
      stat_we = 1'b0; stat_wbits = 3'b000;
      chk(status == 3'b000, "R9 clear rest", status, 0);
      repeat (3) step();
      chk(core_en && osc_en, "R9 still running", {osc_en, core_en}, 3);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule